// File: doc/BRIEF.md
# Exception entry sequencer

The block carries out the architectural state change that a processor makes at the moment it enters an exception handler. One synchronous fault is presented at a time. It comes with its cause, a reason code, a store flag and the faulting effective address. Two level-sensitive asynchronous requests, an external interrupt and a decrementer interrupt, are presented on their own lines. On the clock edge that accepts a request, the block registers five values and raises a one-cycle redirect pulse:

- the saved return address;
- the saved state word;
- the new machine state;
- the fault status and fault address;
- the handler address.

The surrounding pipeline supplies the live machine state on `state_in`. It writes `state_out` back as the live state after a redirect, and it fetches from `redirect_pc`. A one-cycle busy window follows every accepted request. Ordering between simultaneous synchronous faults is settled upstream.

All bit positions in this brief use big-endian numbering. Bit 0 is the most significant bit of a 64-bit word, or of the 32-bit fault status word. State bits used:

| Bit | Meaning |
|-----|---------|
| 0 | 64-bit mode |
| 45 | power management |
| 48 | interrupt enable (EN) |
| 49 | problem state |
| 50 | FP available |
| 52 | FP exception mode 0 |
| 53 | single-step trace |
| 54 | branch trace |
| 55 | FP exception mode 1 |
| 57 | vector prefix (PF) |
| 58 | instruction relocate |
| 59 | data relocate |
| 62 | recoverable (RC) |

Cause codes on `exc_cause`:

| Code | Cause |
|------|-------|
| 0 | machine check |
| 1 | data storage |
| 2 | instruction storage |
| 3 | alignment |
| 4 | program |
| 5 | FP unavailable |
| 6 | system call |
| 7 | FP assist |

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, and after its release with no request, every output reads zero.
- R2: An accepted request raises `redirect` (and `busy`) for exactly the one cycle after the accepting edge. `redirect_pc` is then the base plus the offset of the cause. Offsets: machine check 0x200, data storage 0x300, instruction storage 0x400, external 0x500, alignment 0x600, program 0x700, FP unavailable 0x800, decrementer 0x900, system call 0xC00, FP assist 0xE00.
- R3: The base is all ones in bits 0..43 and zero elsewhere when old state bit 57 (PF) is set, and zero when PF is clear.
- R4: `state_out` equals the old state with bits 45, 48, 49, 50, 52, 53, 54, 55, 58, 59 and 62 cleared and bit 0 set; all other bits are kept.
- R5: `save_state` equals the old state ANDed with a mask of bits 0..32, 37..41 and 48..63, ORed with the reason bits of R10/R11 (none for other causes).
- R6: `save_pc` equals `cur_pc` for every cause except system call, which saves `cur_pc` + 4.
- R7: External and decrementer requests are accepted only while old state bit 48 (EN) is set. When they are accepted, `ext_taken` or `dec_taken` pulses with `redirect`. With EN clear, they produce no pulse and change no output register, and a request still held is taken once EN is set.
- R8: Priority is: synchronous fault first, then external, then decrementer.
- R9: A data storage fault loads `fault_addr` with `fault_ea`. It loads `fault_status` with one reason bit (reason 0 direct-store error → bit 0, 1 translation miss → bit 1, 2 protection → bit 4, 3 external-access violation → bit 11, 4 segment miss → bit 10, 5 external-access disabled → bit 12, 6..7 none), plus bit 6 when `exc_store` is set.
- R10: An instruction storage fault ORs one reason bit into `save_state`: reason 0 translation miss → bit 33, 1 direct-store → bit 35, 2 protection → bit 36, 3 segment miss → bit 43, other codes none.
- R11: A program fault ORs one reason bit into `save_state`: reason 0 illegal → bit 44, 1 privileged → bit 45, 2 trap → bit 46, other codes none.
- R12: An alignment fault loads `fault_addr` with `fault_ea` and clears `fault_status`. All causes other than data storage and alignment leave both registers unchanged.
- R13: `unrecoverable` pulses with `redirect` when the accepted request found old state bit 62 (RC) clear.
- R14: In the busy cycle after an acceptance, no request is taken and the output registers hold. A request still present afterwards is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Synchronous fault present |
| exc_cause | input | 3 | Cause code of the fault |
| exc_reason | input | 3 | Reason code within the cause |
| exc_store | input | 1 | Faulting access was a store |
| cur_pc | input | 64 | Address of the current instruction |
| fault_ea | input | 64 | Faulting effective address |
| state_in | input | 64 | Live machine state |
| ext_irq | input | 1 | External interrupt request (level) |
| dec_irq | input | 1 | Decrementer interrupt request (level) |
| save_pc | output | 64 | Saved return address |
| save_state | output | 64 | Saved state word |
| state_out | output | 64 | New machine state |
| fault_status | output | SW (32) | Fault status word |
| fault_addr | output | 64 | Fault address |
| redirect_pc | output | 64 | Handler address |
| redirect | output | 1 | One-cycle restart pulse |
| busy | output | 1 | Acceptance blocked this cycle |
| ext_taken | output | 1 | External request delivered |
| dec_taken | output | 1 | Decrementer request delivered |
| unrecoverable | output | 1 | Entry taken with RC clear |

## Verification
The assertions check several properties on every cycle:
- a redirect never lasts two cycles, and nothing is accepted while busy;
- an external delivery is always preceded by a set EN bit;
- every new state has mode set and EN and RC cleared;
- the upper bits of the handler address match the prefix bit;
- a system call saves the advanced address;
- an unrecoverable flag never stands without a redirect.

Only the bench scenarios can show the rest:
- the exact offset and reason-bit encoding per cause;
- the masked saved state;
- the fault register updates and the registers that must hold;
- the priority order and the re-acceptance of requests held over a busy or disabled window.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN  = 64;
  localparam int OFS_W = 12;

  typedef enum logic [2:0] {
    CS_MCHK  = 3'd0,
    CS_DSTOR = 3'd1,
    CS_ISTOR = 3'd2,
    CS_ALIGN = 3'd3,
    CS_PROG  = 3'd4,
    CS_FPUN  = 3'd5,
    CS_SCALL = 3'd6,
    CS_FPAS  = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_DEC  = 2'd3
  } src_e;

  // state bit indices, converted from big-endian numbering
  localparam int M_SF   = XLEN - 1 - 0;
  localparam int M_POW  = XLEN - 1 - 45;
  localparam int M_EN   = XLEN - 1 - 48;
  localparam int M_PR   = XLEN - 1 - 49;
  localparam int M_FP   = XLEN - 1 - 50;
  localparam int M_FE0  = XLEN - 1 - 52;
  localparam int M_SE   = XLEN - 1 - 53;
  localparam int M_BE   = XLEN - 1 - 54;
  localparam int M_FE1  = XLEN - 1 - 55;
  localparam int M_PF   = XLEN - 1 - 57;
  localparam int M_IR   = XLEN - 1 - 58;
  localparam int M_DR   = XLEN - 1 - 59;
  localparam int M_RC   = XLEN - 1 - 62;

  function automatic logic [XLEN-1:0] clear_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[M_POW] = 1'b1; m[M_EN]  = 1'b1; m[M_PR] = 1'b1; m[M_FP] = 1'b1;
    m[M_FE0] = 1'b1; m[M_SE]  = 1'b1; m[M_BE] = 1'b1; m[M_FE1] = 1'b1;
    m[M_IR]  = 1'b1; m[M_DR]  = 1'b1; m[M_RC] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] keep_mask();
    logic [XLEN-1:0] m;
    for (int n = 0; n < XLEN; n++)
      m[XLEN-1-n] = (n <= 32) || (n >= 37 && n <= 41) || (n >= 48);
    return m;
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic sync_req,
  input  logic ext_req,
  input  logic dec_req,
  input  logic ints_on,
  input  logic busy,
  output src_e src,
  output logic accept
);
  always_comb begin
    src = SRC_NONE;
    if (!busy) begin
      if (sync_req)                src = SRC_SYNC;
      else if (ext_req && ints_on) src = SRC_EXT;
      else if (dec_req && ints_on) src = SRC_DEC;
    end
    accept = (src != SRC_NONE);
  end
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_pkg::*;
#(
  parameter int BASE_ONES = 44
) (
  input  src_e            src,
  input  cause_e          cause,
  input  logic            prefix_on,
  output logic [XLEN-1:0] target
);
  localparam logic [XLEN-1:0] BASE_VAL =
    {{BASE_ONES{1'b1}}, {(XLEN-BASE_ONES){1'b0}}};

  logic [OFS_W-1:0] offset;

  always_comb begin
    unique case (src)
      SRC_EXT: offset = 12'h500;
      SRC_DEC: offset = 12'h900;
      default: begin
        unique case (cause)
          CS_MCHK:  offset = 12'h200;
          CS_DSTOR: offset = 12'h300;
          CS_ISTOR: offset = 12'h400;
          CS_ALIGN: offset = 12'h600;
          CS_PROG:  offset = 12'h700;
          CS_FPUN:  offset = 12'h800;
          CS_SCALL: offset = 12'hC00;
          default:  offset = 12'hE00;
        endcase
      end
    endcase
    target = (prefix_on ? BASE_VAL : '0) + XLEN'(offset);
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
(
  input  src_e            src,
  input  cause_e          cause,
  input  logic [2:0]      reason,
  input  logic [XLEN-1:0] old_state,
  output logic [XLEN-1:0] new_state,
  output logic [XLEN-1:0] saved_state
);
  localparam logic [XLEN-1:0] CLR  = clear_mask();
  localparam logic [XLEN-1:0] KEEP = keep_mask();

  logic [XLEN-1:0] why;

  always_comb begin
    why = '0;
    if (src == SRC_SYNC && cause == CS_ISTOR) begin
      unique case (reason)
        3'd0:    why[XLEN-1-33] = 1'b1;
        3'd1:    why[XLEN-1-35] = 1'b1;
        3'd2:    why[XLEN-1-36] = 1'b1;
        3'd3:    why[XLEN-1-43] = 1'b1;
        default: why = '0;
      endcase
    end else if (src == SRC_SYNC && cause == CS_PROG) begin
      unique case (reason)
        3'd0:    why[XLEN-1-44] = 1'b1;
        3'd1:    why[XLEN-1-45] = 1'b1;
        3'd2:    why[XLEN-1-46] = 1'b1;
        default: why = '0;
      endcase
    end
    new_state         = old_state & ~CLR;
    new_state[M_SF]   = 1'b1;
    saved_state       = (old_state & KEEP) | why;
  end
endmodule

// File: rtl/exc_fault_calc.sv
module exc_fault_calc
  import exc_pkg::*;
#(
  parameter int SW = 32
) (
  input  src_e            src,
  input  cause_e          cause,
  input  logic [2:0]      reason,
  input  logic            store,
  input  logic [XLEN-1:0] ea,
  input  logic [SW-1:0]   status_q,
  input  logic [XLEN-1:0] addr_q,
  output logic [SW-1:0]   status_d,
  output logic [XLEN-1:0] addr_d
);
  logic [SW-1:0] code;

  always_comb begin
    code = '0;
    unique case (reason)
      3'd0:    code[SW-1-0]  = 1'b1;
      3'd1:    code[SW-1-1]  = 1'b1;
      3'd2:    code[SW-1-4]  = 1'b1;
      3'd3:    code[SW-1-11] = 1'b1;
      3'd4:    code[SW-1-10] = 1'b1;
      3'd5:    code[SW-1-12] = 1'b1;
      default: code = '0;
    endcase
    code[SW-1-6] = store;

    status_d = status_q;
    addr_d   = addr_q;
    if (src == SRC_SYNC && cause == CS_DSTOR) begin
      status_d = code;
      addr_d   = ea;
    end else if (src == SRC_SYNC && cause == CS_ALIGN) begin
      status_d = '0;
      addr_d   = ea;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int SW         = 32,
  parameter int BASE_ONES  = 44,
  parameter int SCALL_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exc_valid,
  input  logic [2:0]           exc_cause,
  input  logic [2:0]           exc_reason,
  input  logic                 exc_store,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [XLEN-1:0]      fault_ea,
  input  logic [XLEN-1:0]      state_in,
  input  logic                 ext_irq,
  input  logic                 dec_irq,
  output logic [XLEN-1:0]      save_pc,
  output logic [XLEN-1:0]      save_state,
  output logic [XLEN-1:0]      state_out,
  output logic [SW-1:0]        fault_status,
  output logic [XLEN-1:0]      fault_addr,
  output logic [XLEN-1:0]      redirect_pc,
  output logic                 redirect,
  output logic                 busy,
  output logic                 ext_taken,
  output logic                 dec_taken,
  output logic                 unrecoverable
);
  cause_e          cause;
  src_e            src;
  logic            accept;
  logic [XLEN-1:0] tgt_d, nstate_d, sstate_d, spc_d, faddr_d;
  logic [SW-1:0]   fstat_d;
  logic            is_scall;

  assign cause = cause_e'(exc_cause);

  exc_arb u_arb (
    .sync_req (exc_valid),
    .ext_req  (ext_irq),
    .dec_req  (dec_irq),
    .ints_on  (state_in[M_EN]),
    .busy     (busy),
    .src      (src),
    .accept   (accept)
  );

  exc_vec_calc #(.BASE_ONES(BASE_ONES)) u_vec (
    .src       (src),
    .cause     (cause),
    .prefix_on (state_in[M_PF]),
    .target    (tgt_d)
  );

  exc_state_calc u_state (
    .src         (src),
    .cause       (cause),
    .reason      (exc_reason),
    .old_state   (state_in),
    .new_state   (nstate_d),
    .saved_state (sstate_d)
  );

  exc_fault_calc #(.SW(SW)) u_fault (
    .src      (src),
    .cause    (cause),
    .reason   (exc_reason),
    .store    (exc_store),
    .ea       (fault_ea),
    .status_q (fault_status),
    .addr_q   (fault_addr),
    .status_d (fstat_d),
    .addr_d   (faddr_d)
  );

  always_comb begin
    is_scall = (src == SRC_SYNC) && (cause == CS_SCALL);
    spc_d    = is_scall ? cur_pc + XLEN'(SCALL_STEP) : cur_pc;
  end

  // architectural registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_pc      <= '0;
      save_state   <= '0;
      state_out    <= '0;
      fault_status <= '0;
      fault_addr   <= '0;
      redirect_pc  <= '0;
    end else if (accept) begin
      save_pc      <= spc_d;
      save_state   <= sstate_d;
      state_out    <= nstate_d;
      fault_status <= fstat_d;
      fault_addr   <= faddr_d;
      redirect_pc  <= tgt_d;
    end
  end

  // one-cycle pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect      <= 1'b0;
      busy          <= 1'b0;
      ext_taken     <= 1'b0;
      dec_taken     <= 1'b0;
      unrecoverable <= 1'b0;
    end else begin
      redirect      <= accept;
      busy          <= accept;
      ext_taken     <= accept && (src == SRC_EXT);
      dec_taken     <= accept && (src == SRC_DEC);
      unrecoverable <= accept && !state_in[M_RC];
    end
  end

  assert_pulse_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  assert_busy_blocks_R14: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  assert_ext_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (src == SRC_EXT) |=> ext_taken && $past(state_in[M_EN]));

  assert_new_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> state_out[M_SF] && !state_out[M_EN] && !state_out[M_RC]);

  assert_base_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (redirect_pc[XLEN-1 -: BASE_ONES] ==
                {BASE_ONES{$past(state_in[M_PF])}}));

  assert_scall_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_scall |=> save_pc == $past(cur_pc) + XLEN'(SCALL_STEP));

  assert_unrec_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |-> redirect);
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk, rst_n;
  logic        exc_valid, exc_store, ext_irq, dec_irq;
  logic [2:0]  exc_cause, exc_reason;
  logic [63:0] cur_pc, fault_ea, state_in;
  logic [63:0] save_pc, save_state, state_out, fault_addr, redirect_pc;
  logic [31:0] fault_status;
  logic        redirect, busy, ext_taken, dec_taken, unrecoverable;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic [63:0] e_spc, e_sst, e_nst, e_fad, e_tgt;
  logic [31:0] e_fst;
  logic        e_red, e_ext, e_dec, e_unr;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_reason(exc_reason), .exc_store(exc_store), .cur_pc(cur_pc),
    .fault_ea(fault_ea), .state_in(state_in), .ext_irq(ext_irq),
    .dec_irq(dec_irq), .save_pc(save_pc), .save_state(save_state),
    .state_out(state_out), .fault_status(fault_status),
    .fault_addr(fault_addr), .redirect_pc(redirect_pc), .redirect(redirect),
    .busy(busy), .ext_taken(ext_taken), .dec_taken(dec_taken),
    .unrecoverable(unrecoverable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] b64(input int n);
    return 64'd1 << (63 - n);
  endfunction

  function automatic logic [31:0] b32(input int n);
    return 32'd1 << (31 - n);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    exc_valid = 0; exc_cause = 0; exc_reason = 0; exc_store = 0;
    ext_irq = 0; dec_irq = 0;
  endtask

  // expected entry computation from the requirements
  task automatic model();
    int src;
    logic [63:0] clr, keep, why, base;
    logic [11:0] off;
    logic [11:0] offs [8];
    offs = '{12'h200, 12'h300, 12'h400, 12'h600, 12'h700, 12'h800, 12'hC00, 12'hE00};
    src = 0;
    if (exc_valid) src = 1;
    else if (ext_irq && state_in[63-48]) src = 2;
    else if (dec_irq && state_in[63-48]) src = 3;
    e_red = (src != 0); e_ext = (src == 2); e_dec = (src == 3);
    e_unr = (src != 0) && !state_in[63-62];
    if (src == 0) return;
    clr = b64(45) | b64(48) | b64(49) | b64(50) | b64(52) | b64(53) |
          b64(54) | b64(55) | b64(58) | b64(59) | b64(62);
    keep = '0;
    for (int n = 0; n < 64; n++)
      if (n <= 32 || (n >= 37 && n <= 41) || n >= 48) keep |= b64(n);
    why = '0;
    if (src == 1 && exc_cause == 2)
      case (exc_reason) 0: why = b64(33); 1: why = b64(35);
                        2: why = b64(36); 3: why = b64(43); default: ; endcase
    if (src == 1 && exc_cause == 4)
      case (exc_reason) 0: why = b64(44); 1: why = b64(45);
                        2: why = b64(46); default: ; endcase
    base = '0;
    if (state_in[63-57]) for (int n = 0; n <= 43; n++) base |= b64(n);
    off = (src == 2) ? 12'h500 : (src == 3) ? 12'h900 : offs[exc_cause];
    e_tgt = base + {52'd0, off};
    e_nst = (state_in & ~clr) | b64(0);
    e_sst = (state_in & keep) | why;
    e_spc = (src == 1 && exc_cause == 6) ? cur_pc + 64'd4 : cur_pc;
    if (src == 1 && exc_cause == 1) begin
      e_fad = fault_ea;
      case (exc_reason)
        0: e_fst = b32(0);  1: e_fst = b32(1);  2: e_fst = b32(4);
        3: e_fst = b32(11); 4: e_fst = b32(10); 5: e_fst = b32(12);
        default: e_fst = '0;
      endcase
      if (exc_store) e_fst |= b32(6);
    end
    if (src == 1 && exc_cause == 3) begin
      e_fad = fault_ea; e_fst = '0;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "redirect", {63'd0, redirect}, {63'd0, e_red});
    chk(tag, "busy", {63'd0, busy}, {63'd0, e_red});
    chk(tag, "ext_taken", {63'd0, ext_taken}, {63'd0, e_ext});
    chk(tag, "dec_taken", {63'd0, dec_taken}, {63'd0, e_dec});
    chk(tag, "unrecoverable", {63'd0, unrecoverable}, {63'd0, e_unr});
    chk(tag, "save_pc", save_pc, e_spc);
    chk(tag, "save_state", save_state, e_sst);
    chk(tag, "state_out", state_out, e_nst);
    chk(tag, "fault_status", {32'd0, fault_status}, {32'd0, e_fst});
    chk(tag, "fault_addr", fault_addr, e_fad);
    chk(tag, "redirect_pc", redirect_pc, e_tgt);
  endtask

  // inputs already driven; accept edge, check, then one idle cycle
  task automatic step(input string tag);
    model();
    @(posedge clk); @(negedge clk);
    compare(tag);
    drive_idle();
    @(posedge clk); @(negedge clk);
    chk(tag, "idle redirect", {63'd0, redirect}, 64'd0);
    chk(tag, "idle busy", {63'd0, busy}, 64'd0);
  endtask

  task automatic set_sync(input int c, input int r, input logic st,
                          input logic [63:0] pc, input logic [63:0] ea,
                          input logic [63:0] ms);
    exc_valid = 1; exc_cause = 3'(c); exc_reason = 3'(r); exc_store = st;
    cur_pc = pc; fault_ea = ea; state_in = ms;
  endtask

  localparam logic [63:0] ST_OK = 64'h0000_0000_0000_C002 | (64'd1 << (63-48)) | (64'd1 << (63-62));

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [63:0] ms;
    void'($urandom(32'd20240611));
    drive_idle();
    cur_pc = 0; fault_ea = 0; state_in = 0; rst_n = 0;
    {e_spc, e_sst, e_nst, e_fad, e_tgt} = '0; e_fst = '0;
    {e_red, e_ext, e_dec, e_unr} = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    compare("R1");

    // every synchronous cause, both base choices (R2, R3, R4, R5, R6)
    for (int c = 0; c < 8; c++) begin
      set_sync(c, 0, 0, 64'h0000_1234_5678_9A00 + 64'(c * 16), 64'hABCD_0000 + 64'(c), ST_OK);
      step("R2");
      set_sync(c, 1, 1, 64'h0000_0000_0040_0100, 64'h77, ST_OK | b64(57) | b64(45) | b64(50));
      step("R3");
    end
    // system call saves address + 4 (R6)
    set_sync(6, 0, 0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, ST_OK);
    step("R6");
    // data storage reasons, load and store (R9)
    for (int r = 0; r < 8; r++) begin
      set_sync(1, r, r[0], 64'h1000 + 64'(r), 64'hDEAD_0000 + 64'(r), ST_OK);
      step("R9");
    end
    // instruction storage and program reasons (R10, R11)
    for (int r = 0; r < 5; r++) begin
      set_sync(2, r, 0, 64'h2000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      step("R10");
      set_sync(4, r, 0, 64'h3000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      step("R11");
    end
    // alignment clears status, then machine check leaves both (R12)
    set_sync(1, 2, 1, 64'h4000, 64'h5555, ST_OK);
    step("R9");
    set_sync(3, 0, 0, 64'h4004, 64'h6666, ST_OK);
    step("R12");
    set_sync(0, 0, 0, 64'h4008, 64'h9999, ST_OK);
    step("R12");
    set_sync(5, 0, 1, 64'h400C, 64'hAAAA, ST_OK);
    step("R12");

    // gating by EN: held external request waits (R7)
    drive_idle(); ext_irq = 1; state_in = ST_OK & ~b64(48); cur_pc = 64'h5000;
    step("R7");
    ext_irq = 1; dec_irq = 1; state_in = ST_OK & ~b64(48);
    step("R7");
    ext_irq = 1; state_in = ST_OK; cur_pc = 64'h5004;
    step("R7");
    dec_irq = 1; state_in = ST_OK | b64(57); cur_pc = 64'h5008;
    step("R7");
    // priority (R8)
    set_sync(7, 0, 0, 64'h6000, 64'h0, ST_OK); ext_irq = 1; dec_irq = 1;
    step("R8");
    drive_idle(); ext_irq = 1; dec_irq = 1; state_in = ST_OK; cur_pc = 64'h6004;
    step("R8");
    // unrecoverable entry (R13)
    set_sync(4, 2, 0, 64'h7000, 64'h0, ST_OK & ~b64(62));
    step("R13");
    drive_idle(); dec_irq = 1; state_in = ST_OK & ~b64(62); cur_pc = 64'h7004;
    step("R13");

    // busy cycle ignores a request, held request then taken (R14)
    set_sync(0, 0, 0, 64'h8000, 64'h0, ST_OK);
    model();
    @(posedge clk); @(negedge clk);
    compare("R14");
    set_sync(6, 0, 0, 64'h8100, 64'h0, ST_OK | b64(57));
    @(posedge clk); @(negedge clk);
    chk("R14", "busy-cycle redirect", {63'd0, redirect}, 64'd0);
    chk("R14", "busy-cycle save_pc", save_pc, 64'h8000);
    chk("R14", "busy-cycle redirect_pc", redirect_pc, 64'h200);
    step("R14");

    // constrained random mix (R2..R13)
    for (int i = 0; i < 400; i++) begin
      ms = {$urandom, $urandom};
      if (($urandom % 4) != 0) ms |= b64(62);
      exc_valid  = (($urandom % 3) != 0);
      exc_cause  = 3'($urandom);
      exc_reason = 3'($urandom);
      exc_store  = 1'($urandom);
      cur_pc     = {$urandom, $urandom} & ~64'd3;
      fault_ea   = {$urandom, $urandom};
      state_in   = ms;
      ext_irq    = 1'($urandom);
      dec_irq    = 1'($urandom);
      step("R5");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule